// File: doc/BRIEF.md
# Four-Digit Seven-Segment Decoder with Zero Suppression

This block turns a row of four 4-bit digit codes (hexadecimal 0 to F, so plain BCD works unchanged) into four active-low seven-segment patterns for a common-anode display. Each digit position carries a small blanking cell. The cells are chained so that zeros with no significance go dark, while zeros that carry meaning stay lit.

A leading chain starts at the most significant digit and runs downward. It blanks zeros until it meets the first nonzero digit. It always stops at the units digit, which is the digit just left of the decimal point. A second, optional chain starts at the least significant digit and runs upward. It blanks zeros that follow the decimal point, and it also stops at the units digit. The integer part is never touched by it, so a value such as 450 keeps both of its zeros.

The decode and both chains are combinational. The segment vectors and both sets of chain flags are registered on the rising clock edge, and a synchronous reset darkens every digit.

Top module: `disp_rb_decoder`

## Requirements
- R1: Segment vector bit 0 is segment a and bit 6 is segment g, and a segment lights when its bit is 0. Digit values 0..F give these active-high patterns (bit 6..0), which are then inverted: 0=3F 1=06 2=5B 3=4F 4=66 5=6D 6=7D 7=07 8=7F 9=6F A=77 B=7C C=39 D=5E E=79 F=71. A blanked digit outputs 7F.
- R2: Every output shows the inputs sampled at the previous rising clock edge. While `rst` is high at an edge, all segment vectors become 7F and all chain flags become 1.
- R3: Digit index 3 is most significant. The leading chain input of digit 3 is asserted (low). Digit i with i > `point_pos_i` blanks when its value is 0 and its leading chain input is asserted. Its `lead_rbo_n_o[i]` is low exactly when it blanks, and that flag is the chain input of digit i-1.
- R4: Once a digit above the units digit is shown, no lower digit is blanked by the leading chain. Interior zeros stay lit, for example 0100 shows as "100" and 1024 shows all four digits.
- R5: `point_pos_i` gives the index of the units digit. That digit is never blanked by either chain, so an all-zero value shows a single 0 there. Its chain flags are 1.
- R6: With `trail_mode_i` = 1, the trailing chain input of digit 0 is asserted. Digit i with i < `point_pos_i` blanks when its value is 0 and its trailing chain input is asserted. `trail_rbo_n_o[i]` is low exactly when it blanks, and that flag is the chain input of digit i+1.
- R7: With `trail_mode_i` = 0, no digit is blanked by the trailing chain and every `trail_rbo_n_o` bit is 1.
- R8: With `point_pos_i` = 0 there are no fractional digits, so the trailing chain blanks nothing even in trailing mode. Zeros that fix the magnitude, as in 0450, remain lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| digits_i | input | 16 | Four digit codes, digit i in bits 4i+3..4i, digit 3 most significant |
| point_pos_i | input | 2 | Index of the units digit (decimal point on its right) |
| trail_mode_i | input | 1 | 1 enables trailing-zero suppression after the point |
| seg_n_o | output | 28 | Four active-low segment vectors, digit i in bits 7i+6..7i |
| lead_rbo_n_o | output | 4 | Leading chain blanking outputs, active low, one per digit |
| trail_rbo_n_o | output | 4 | Trailing chain blanking outputs, active low, one per digit |

## Verification
On every cycle the assertions check the following properties. A lit leading flag always goes with a dark digit. A dark digit always had a zero value one cycle earlier. The leading chain never restarts once it has stopped. The units digit is never dark. With trailing mode off, no trailing flag is set. The correct glyph for each code, and the exact stopping point of each chain, can only be shown by the bench's scenarios. These scenarios compare every cycle against a behavioural model: the full hex sweep, interior zeros, all-zero values, values with the point in different positions, and trailing mode turned on and off over the same digits.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int NIB_W = 4;
    localparam int SEG_W = 7;
    localparam logic [SEG_W-1:0] SEG_DARK = '1;

    // Active-low glyph, bit 0 = segment a ... bit 6 = segment g
    function automatic logic [SEG_W-1:0] glyph_n(input logic [NIB_W-1:0] val);
        logic [SEG_W-1:0] lit;
        unique case (val)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h6F;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            default: lit = 7'h71;
        endcase
        return ~lit;
    endfunction

endpackage

// File: rtl/rb_cell.sv
// One link of a zero-suppression chain.
module rb_cell (
    input  logic zero_i,    // digit value is zero
    input  logic allow_i,   // this position may be blanked by this chain
    input  logic rbi_n_i,   // chain input, active low
    output logic blank_o,
    output logic rbo_n_o    // chain output, active low
);
    always_comb begin
        blank_o = zero_i && allow_i && !rbi_n_i;
        rbo_n_o = !blank_o;
    end
endmodule

// File: rtl/seg_glyph.sv
module seg_glyph
    import disp_pkg::*;
(
    input  logic [NIB_W-1:0] val_i,
    input  logic             blank_i,
    output logic [SEG_W-1:0] seg_n_o
);
    always_comb begin
        seg_n_o = blank_i ? SEG_DARK : glyph_n(val_i);
    end
endmodule

// File: rtl/disp_rb_decoder.sv
module disp_rb_decoder
    import disp_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [DIGITS*NIB_W-1:0]   digits_i,
    input  logic [$clog2(DIGITS)-1:0] point_pos_i,
    input  logic                      trail_mode_i,
    output logic [DIGITS*SEG_W-1:0]   seg_n_o,
    output logic [DIGITS-1:0]         lead_rbo_n_o,
    output logic [DIGITS-1:0]         trail_rbo_n_o
);
    localparam int PW   = $clog2(DIGITS);
    localparam int TOPI = DIGITS - 1;

    logic [DIGITS-1:0]       lead_rbi_n, lead_rbo_n, lead_blank;
    logic [DIGITS-1:0]       trail_rbi_n, trail_rbo_n, trail_blank;
    logic [DIGITS*SEG_W-1:0] seg_n_c;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [NIB_W-1:0] val;
        logic             is_zero;
        logic             lead_ok;
        logic             trail_ok;

        assign val      = digits_i[i*NIB_W +: NIB_W];
        assign is_zero  = (val == '0);
        assign lead_ok  = (PW'(i) > point_pos_i);
        assign trail_ok = (PW'(i) < point_pos_i);

        if (i == TOPI) begin : g_lead_head
            assign lead_rbi_n[i] = 1'b0;
        end else begin : g_lead_link
            assign lead_rbi_n[i] = lead_rbo_n[i+1];
        end

        if (i == 0) begin : g_trail_head
            assign trail_rbi_n[i] = !trail_mode_i;
        end else begin : g_trail_link
            assign trail_rbi_n[i] = trail_rbo_n[i-1];
        end

        rb_cell u_lead (
            .zero_i  (is_zero),
            .allow_i (lead_ok),
            .rbi_n_i (lead_rbi_n[i]),
            .blank_o (lead_blank[i]),
            .rbo_n_o (lead_rbo_n[i])
        );

        rb_cell u_trail (
            .zero_i  (is_zero),
            .allow_i (trail_ok),
            .rbi_n_i (trail_rbi_n[i]),
            .blank_o (trail_blank[i]),
            .rbo_n_o (trail_rbo_n[i])
        );

        seg_glyph u_glyph (
            .val_i   (val),
            .blank_i (lead_blank[i] || trail_blank[i]),
            .seg_n_o (seg_n_c[i*SEG_W +: SEG_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_n_o       <= '1;
            lead_rbo_n_o  <= '1;
            trail_rbo_n_o <= '1;
        end else begin
            seg_n_o       <= seg_n_c;
            lead_rbo_n_o  <= lead_rbo_n;
            trail_rbo_n_o <= trail_rbo_n;
        end
    end

endmodule

// File: rtl/disp_rb_checker.sv
module disp_rb_checker
    import disp_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic [DIGITS*NIB_W-1:0]   digits_i,
    input logic [$clog2(DIGITS)-1:0] point_pos_i,
    input logic                      trail_mode_i,
    input logic [DIGITS*SEG_W-1:0]   seg_n_o,
    input logic [DIGITS-1:0]         lead_rbo_n_o,
    input logic [DIGITS-1:0]         trail_rbo_n_o
);
    localparam int PW = $clog2(DIGITS);

    // High once the outputs reflect a sampled input rather than reset
    logic past_ok;
    always_ff @(posedge clk) begin
        past_ok <= !rst;
    end

    p_reset_dark_r2: assert property (@(posedge clk) disable iff (rst)
        !past_ok |-> ((&seg_n_o) && (&lead_rbo_n_o) && (&trail_rbo_n_o)));

    p_trail_off_r7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(trail_mode_i)) |-> (&trail_rbo_n_o));

    for (genvar i = 0; i < DIGITS; i++) begin : g_chk
        p_rbo_dark_r3: assert property (@(posedge clk) disable iff (rst)
            !lead_rbo_n_o[i] |-> (seg_n_o[i*SEG_W +: SEG_W] == SEG_DARK));

        p_trail_dark_r6: assert property (@(posedge clk) disable iff (rst)
            !trail_rbo_n_o[i] |-> (seg_n_o[i*SEG_W +: SEG_W] == SEG_DARK));

        p_dark_zero_r3: assert property (@(posedge clk) disable iff (rst)
            (past_ok && seg_n_o[i*SEG_W +: SEG_W] == SEG_DARK)
                |-> ($past(digits_i[i*NIB_W +: NIB_W]) == '0));

        p_units_lit_r5: assert property (@(posedge clk) disable iff (rst)
            (past_ok && $past(point_pos_i) == PW'(i))
                |-> (seg_n_o[i*SEG_W +: SEG_W] != SEG_DARK));

        if (i < DIGITS - 1) begin : g_chain
            p_interior_r4: assert property (@(posedge clk) disable iff (rst)
                lead_rbo_n_o[i+1] |-> lead_rbo_n_o[i]);
        end
    end

endmodule

bind disp_rb_decoder disp_rb_checker #(.DIGITS(DIGITS)) u_rb_checker (
    .clk           (clk),
    .rst           (rst),
    .digits_i      (digits_i),
    .point_pos_i   (point_pos_i),
    .trail_mode_i  (trail_mode_i),
    .seg_n_o       (seg_n_o),
    .lead_rbo_n_o  (lead_rbo_n_o),
    .trail_rbo_n_o (trail_rbo_n_o)
);

// File: tb/tb_disp_rb_decoder.sv
`timescale 1ns/1ps
module tb_disp_rb_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] digits_i = '0;
    logic [1:0]  point_pos_i = '0;
    logic        trail_mode_i = 1'b0;
    logic [27:0] seg_n_o;
    logic [3:0]  lead_rbo_n_o;
    logic [3:0]  trail_rbo_n_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    disp_rb_decoder dut (
        .clk           (clk),
        .rst           (rst),
        .digits_i      (digits_i),
        .point_pos_i   (point_pos_i),
        .trail_mode_i  (trail_mode_i),
        .seg_n_o       (seg_n_o),
        .lead_rbo_n_o  (lead_rbo_n_o),
        .trail_rbo_n_o (trail_rbo_n_o)
    );

    // Active-high glyphs from R1, inverted when used
    logic [6:0] lit_tab [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                                 7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};

    // Expected outputs for the inputs that were sampled at the last edge
    logic [27:0] exp_seg;
    logic [3:0]  exp_lead;
    logic [3:0]  exp_trail;

    task automatic model(input logic [15:0] d, input int pos, input bit mode);
        bit chain;
        bit dark [4];
        exp_lead  = '1;
        exp_trail = '1;
        for (int i = 0; i < 4; i++) dark[i] = 1'b0;
        chain = 1'b1;
        for (int i = 3; i >= 0; i--) begin
            if (chain && i > pos && d[i*4 +: 4] == 4'h0) begin
                dark[i] = 1'b1;
                exp_lead[i] = 1'b0;
            end else begin
                chain = 1'b0;
            end
        end
        chain = mode;
        for (int i = 0; i < 4; i++) begin
            if (chain && i < pos && d[i*4 +: 4] == 4'h0) begin
                dark[i] = 1'b1;
                exp_trail[i] = 1'b0;
            end else begin
                chain = 1'b0;
            end
        end
        for (int i = 0; i < 4; i++)
            exp_seg[i*7 +: 7] = dark[i] ? 7'h7F : ~lit_tab[d[i*4 +: 4]];
    endtask

    task automatic compare(input string tag);
        for (int i = 0; i < 4; i++) begin
            checks++;
            if (seg_n_o[i*7 +: 7] !== exp_seg[i*7 +: 7]) begin
                errors++;
                $display("FAIL %s digit %0d seg: actual %h expected %h", tag, i,
                         seg_n_o[i*7 +: 7], exp_seg[i*7 +: 7]);
            end
        end
        checks++;
        if (lead_rbo_n_o !== exp_lead || trail_rbo_n_o !== exp_trail) begin
            errors++;
            $display("FAIL %s flags: actual lead %b trail %b expected lead %b trail %b",
                     tag, lead_rbo_n_o, trail_rbo_n_o, exp_lead, exp_trail);
        end
    endtask

    // Drive away from the edge, then check one edge later (R2 latency)
    task automatic apply(input logic [15:0] d, input int pos, input bit mode, input string tag);
        @(negedge clk);
        digits_i     = d;
        point_pos_i  = 2'(pos);
        trail_mode_i = mode;
        @(negedge clk);
        model(d, pos, mode);
        compare(tag);
    endtask

    task automatic check_reset(input string tag);
        exp_seg   = '1;
        exp_lead  = '1;
        exp_trail = '1;
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset("R2 reset state");
        rst = 1'b0;

        // R1: every code shown, leading digit nonzero so nothing is dark
        for (int v = 0; v < 16; v++)
            apply({4'h1, 4'(v), 4'(v), 4'(v)}, 0, 1'b0, "R1 glyph sweep");
        apply(16'hFEDC, 0, 1'b1, "R1 high codes");

        // R3/R4: leading zeros dark, interior zeros lit
        apply(16'h0100, 0, 1'b0, "R4 interior 100");
        apply(16'h0217, 0, 1'b0, "R3 leading 217");
        apply(16'h1024, 0, 1'b0, "R4 interior 1024");
        apply(16'h0009, 0, 1'b0, "R3 three leading zeros");
        apply(16'h0A00, 0, 1'b0, "R4 hex interior");

        // R5: units digit never dark
        apply(16'h0000, 0, 1'b0, "R5 all zero");
        apply(16'h0000, 2, 1'b1, "R5 all zero point at 2");
        apply(16'h0000, 3, 1'b1, "R5 all zero point at 3");
        apply(16'h0005, 1, 1'b0, "R5 units zero left of point");

        // R6: trailing zeros after the point
        apply(16'h4500, 3, 1'b1, "R6 trailing 4.500");
        apply(16'h1020, 2, 1'b1, "R6 trailing 10.20");
        apply(16'h0300, 2, 1'b1, "R6 both chains 03.00");
        apply(16'h0102, 3, 1'b1, "R6 interior fraction");

        // R7: trailing mode off leaves the fraction lit
        apply(16'h4500, 3, 1'b0, "R7 mode off 4.500");
        apply(16'h0300, 2, 1'b0, "R7 mode off 03.00");

        // R8: no fraction, zeros that fix magnitude stay lit
        apply(16'h0450, 0, 1'b1, "R8 magnitude 450");
        apply(16'h1000, 0, 1'b1, "R8 magnitude 1000");

        // R2: reset in mid-run darkens everything
        @(negedge clk);
        digits_i = 16'h1234;
        rst = 1'b1;
        @(negedge clk);
        check_reset("R2 mid-run reset");
        rst = 1'b0;
        apply(16'h0807, 1, 1'b1, "R2 recovery after reset");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule